// File: doc/BRIEF.md
# Interrupt Register Bank Save Controller

This block sits beside the exception sequencer of a processor core. For each accepted exception it chooses where the interrupted context goes. The context can go into a hardware register bank or onto the stack. It also keeps the bank pointer. An eligible exception is a maskable interrupt, taken while bank usage is enabled. For such an exception, the context is written to the bank that the pointer selects, and the pointer then advances. The context is the fifteen general registers, the global base register, both multiply-accumulate halves, the procedure register and the vector number. All of these fields are written at once, in one clock edge.

When all banks are occupied, a control input selects what happens. Either the context falls back to stack saving with no exception, or a bank-overflow exception is signalled. A return from interrupt asks for a restore. The restore moves the pointer down one bank and presents that bank's contents on the restore outputs. A restore with no banks in use raises an underflow error instead.

Top module: `irq_bank_ctl`

## Requirements
- R1: After reset, `bankPtr` is 0 and `useBank`, `useStack`, `raiseOverflow`, `underflowErr` and `restoreValid` are all 0.
- R2: Each cycle with `excReq` high is followed, exactly one cycle later, by a one-cycle pulse on exactly one of `useBank`, `useStack` and `raiseOverflow`. None of the three is high in a cycle that does not follow an accepted exception.
- R3: Only `excClass` code 0 (maskable interrupt) is eligible for banking. Codes 1 (NMI), 2 (user break), 3 (address error), 4 (bus error), 5 (bank error), 6 (instruction trap) and 7 (reserved) give `useStack` and leave `bankPtr` unchanged.
- R4: A code-0 interrupt with `bankEnable` low gives `useStack` and leaves `bankPtr` unchanged.
- R5: A code-0 interrupt with `bankEnable` high and `bankPtr` below NUM_BANKS gives `useBank`. It stores all context inputs into bank `bankPtr` in that edge and increments `bankPtr`.
- R6: An eligible interrupt with `bankPtr` equal to NUM_BANKS and `overflowEnable` low gives `useStack`. The pointer and all bank contents are left unchanged.
- R7: An eligible interrupt with `bankPtr` equal to NUM_BANKS and `overflowEnable` high gives `raiseOverflow`. The pointer and all bank contents are left unchanged.
- R8: `restoreReq` with `bankPtr` above 0 decrements `bankPtr`. One cycle later `restoreValid` pulses, with the restore outputs equal to the context last saved into bank `bankPtr-1` (last-in, first-out).
- R9: `restoreReq` with `bankPtr` equal to 0 pulses `underflowErr` one cycle later. `bankPtr` stays 0 and `restoreValid` stays low.
- R10: `restoreReq` in the same cycle as `excReq` is ignored: no restore, no underflow, and only the exception acts on the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | One-cycle strobe: an exception has been accepted |
| excClass | input | 3 | Class code of the accepted exception (0 = maskable interrupt) |
| bankEnable | input | 1 | Register bank usage enabled |
| overflowEnable | input | 1 | 1: full banks raise overflow; 0: fall back to stack |
| restoreReq | input | 1 | One-cycle strobe: restore context from the bank on return |
| gprIn | input | NUM_GPR*DATA_W | General registers R0..R14, R0 in the low word |
| gbrIn | input | DATA_W | Global base register |
| machIn | input | DATA_W | Multiply-accumulate high |
| maclIn | input | DATA_W | Multiply-accumulate low |
| prIn | input | DATA_W | Procedure register |
| vecIn | input | VEC_W | Vector number of the interrupt being taken |
| useBank | output | 1 | Context saved to a bank |
| useStack | output | 1 | Context must be pushed on the stack |
| raiseOverflow | output | 1 | Bank-overflow exception to be raised |
| underflowErr | output | 1 | Restore requested with no bank in use |
| restoreValid | output | 1 | Restore outputs hold a restored context |
| bankPtr | output | PTR_W | Number of banks in use |
| gprOut | output | NUM_GPR*DATA_W | Restored general registers |
| gbrOut | output | DATA_W | Restored global base register |
| machOut | output | DATA_W | Restored multiply-accumulate high |
| maclOut | output | DATA_W | Restored multiply-accumulate low |
| prOut | output | DATA_W | Restored procedure register |
| vecOut | output | VEC_W | Restored vector number |

## Verification
The bench fills every bank and then sends eligible interrupts with the overflow control in both settings. A design that compared against the wrong bound, or that wrote past the last bank, shows up here as a moved pointer or a corrupted top entry on the next restore. It restores at pointer 0 and sends a restore together with an exception. An off-by-one design wraps the pointer, and a design with a bad priority restores while saving. It sends every non-interrupt class and bank-disabled interrupts, which catches decode errors that bank a context they should not. Long random save and restore runs compare the restored context field by field against a last-in, first-out model, which exposes wrong read indices or swapped fields.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  typedef enum logic [2:0] {
    EXC_IRQ     = 3'd0,
    EXC_NMI     = 3'd1,
    EXC_UBRK    = 3'd2,
    EXC_ADDRERR = 3'd3,
    EXC_BUSERR  = 3'd4,
    EXC_BANKERR = 3'd5,
    EXC_TRAP    = 3'd6,
    EXC_RSVD    = 3'd7
  } excClass_e;

  // Strobes from control to the bank storage datapath
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } bankStrobe_t;

endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int NUM_BANKS = 15,
  parameter int PTR_W     = $clog2(NUM_BANKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             excReq,
  input  excClass_e        excClass,
  input  logic             bankEnable,
  input  logic             overflowEnable,
  input  logic             restoreReq,
  output logic             useBank,
  output logic             useStack,
  output logic             raiseOverflow,
  output logic             underflowErr,
  output logic             restoreValid,
  output logic [PTR_W-1:0] bankPtr,
  output bankStrobe_t      strobe,
  output logic [PTR_W-1:0] bankIdx
);

  localparam logic [PTR_W-1:0] FULL_PTR = PTR_W'(NUM_BANKS);

  logic eligible;
  logic banksFull;
  logic ptrEmpty;
  logic doSave;
  logic doStack;
  logic doOverflow;
  logic doRestore;
  logic doUnderflow;

  always_comb begin
    eligible    = excReq && (excClass == EXC_IRQ) && bankEnable;
    banksFull   = (bankPtr == FULL_PTR);
    ptrEmpty    = (bankPtr == '0);
    doSave      = eligible && !banksFull;
    doOverflow  = eligible && banksFull && overflowEnable;
    doStack     = excReq && !doSave && !doOverflow;
    doRestore   = restoreReq && !excReq && !ptrEmpty;
    doUnderflow = restoreReq && !excReq && ptrEmpty;
    strobe.wrEn = doSave;
    strobe.rdEn = doRestore;
    bankIdx     = doRestore ? (bankPtr - 1'b1) : bankPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankPtr       <= '0;
      useBank       <= 1'b0;
      useStack      <= 1'b0;
      raiseOverflow <= 1'b0;
      underflowErr  <= 1'b0;
      restoreValid  <= 1'b0;
    end else begin
      useBank       <= doSave;
      useStack      <= doStack;
      raiseOverflow <= doOverflow;
      underflowErr  <= doUnderflow;
      restoreValid  <= doRestore;
      if (doSave) begin
        bankPtr <= bankPtr + 1'b1;
      end else if (doRestore) begin
        bankPtr <= bankPtr - 1'b1;
      end
    end
  end

  AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> $countones({useBank, useStack, raiseOverflow}) == 1) else $error("decision"); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !excReq |=> !(useBank || useStack || raiseOverflow)) else $error("spurious"); // R2
  AST_INELIGIBLE_STACK: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && excClass != EXC_IRQ) |=> useStack && $stable(bankPtr)) else $error("class"); // R3
  AST_DISABLED_STACK: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && !bankEnable) |=> useStack && $stable(bankPtr)) else $error("disabled"); // R4
  AST_PTR_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    bankPtr <= FULL_PTR) else $error("ptr limit"); // R7
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && bankPtr == FULL_PTR) |=> $stable(bankPtr)) else $error("full hold"); // R6
  AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (restoreReq && !excReq && bankPtr == '0) |=> underflowErr && !restoreValid && bankPtr == '0) else $error("underflow"); // R9
  AST_RESTORE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (restoreReq && excReq) |=> !restoreValid && !underflowErr) else $error("collide"); // R10

endmodule

// File: rtl/irq_bank_store.sv
module irq_bank_store
  import irq_bank_pkg::*;
#(
  parameter int NUM_BANKS = 15,
  parameter int NUM_GPR   = 15,
  parameter int DATA_W    = 32,
  parameter int VEC_W     = 8,
  parameter int PTR_W     = $clog2(NUM_BANKS + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bankStrobe_t               strobe,
  input  logic [PTR_W-1:0]          bankIdx,
  input  logic [NUM_GPR*DATA_W-1:0] gprIn,
  input  logic [DATA_W-1:0]         gbrIn,
  input  logic [DATA_W-1:0]         machIn,
  input  logic [DATA_W-1:0]         maclIn,
  input  logic [DATA_W-1:0]         prIn,
  input  logic [VEC_W-1:0]          vecIn,
  output logic [NUM_GPR*DATA_W-1:0] gprOut,
  output logic [DATA_W-1:0]         gbrOut,
  output logic [DATA_W-1:0]         machOut,
  output logic [DATA_W-1:0]         maclOut,
  output logic [DATA_W-1:0]         prOut,
  output logic [VEC_W-1:0]          vecOut
);

  localparam int NUM_WORDS = NUM_GPR + 4;
  localparam int WORDS_W   = NUM_WORDS * DATA_W;
  localparam int ENTRY_W   = WORDS_W + VEC_W;

  logic [WORDS_W-1:0] wordsIn;
  logic [WORDS_W-1:0] wordsOut;
  logic [ENTRY_W-1:0] entryIn;
  logic [ENTRY_W-1:0] entryOut;
  logic [ENTRY_W-1:0] bankMem [NUM_BANKS];

  // Word slot k of an entry: GPRs first, then GBR, MACH, MACL, PR
  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_pack
    if (k < NUM_GPR) begin : g_gpr
      assign wordsIn[k*DATA_W +: DATA_W] = gprIn[k*DATA_W +: DATA_W];
      assign gprOut[k*DATA_W +: DATA_W]  = wordsOut[k*DATA_W +: DATA_W];
    end else if (k == NUM_GPR) begin : g_gbr
      assign wordsIn[k*DATA_W +: DATA_W] = gbrIn;
      assign gbrOut = wordsOut[k*DATA_W +: DATA_W];
    end else if (k == NUM_GPR + 1) begin : g_mach
      assign wordsIn[k*DATA_W +: DATA_W] = machIn;
      assign machOut = wordsOut[k*DATA_W +: DATA_W];
    end else if (k == NUM_GPR + 2) begin : g_macl
      assign wordsIn[k*DATA_W +: DATA_W] = maclIn;
      assign maclOut = wordsOut[k*DATA_W +: DATA_W];
    end else begin : g_pr
      assign wordsIn[k*DATA_W +: DATA_W] = prIn;
      assign prOut = wordsOut[k*DATA_W +: DATA_W];
    end
  end

  assign entryIn  = {vecIn, wordsIn};
  assign wordsOut = entryOut[WORDS_W-1:0];
  assign vecOut   = entryOut[ENTRY_W-1:WORDS_W];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      bankMem[bankIdx] <= entryIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryOut <= '0;
    end else if (strobe.rdEn) begin
      entryOut <= bankMem[bankIdx];
    end
  end

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (int'(bankIdx) < NUM_BANKS)) else $error("write range"); // R7
  AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |-> (int'(bankIdx) < NUM_BANKS)) else $error("read range"); // R8
  AST_NO_RW_COLLIDE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEn && strobe.rdEn)) else $error("collide"); // R10

endmodule

// File: rtl/irq_bank_ctl.sv
module irq_bank_ctl
  import irq_bank_pkg::*;
#(
  parameter int NUM_BANKS = 15,
  parameter int NUM_GPR   = 15,
  parameter int DATA_W    = 32,
  parameter int VEC_W     = 8,
  parameter int PTR_W     = $clog2(NUM_BANKS + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      excReq,
  input  logic [2:0]                excClass,
  input  logic                      bankEnable,
  input  logic                      overflowEnable,
  input  logic                      restoreReq,
  input  logic [NUM_GPR*DATA_W-1:0] gprIn,
  input  logic [DATA_W-1:0]         gbrIn,
  input  logic [DATA_W-1:0]         machIn,
  input  logic [DATA_W-1:0]         maclIn,
  input  logic [DATA_W-1:0]         prIn,
  input  logic [VEC_W-1:0]          vecIn,
  output logic                      useBank,
  output logic                      useStack,
  output logic                      raiseOverflow,
  output logic                      underflowErr,
  output logic                      restoreValid,
  output logic [PTR_W-1:0]          bankPtr,
  output logic [NUM_GPR*DATA_W-1:0] gprOut,
  output logic [DATA_W-1:0]         gbrOut,
  output logic [DATA_W-1:0]         machOut,
  output logic [DATA_W-1:0]         maclOut,
  output logic [DATA_W-1:0]         prOut,
  output logic [VEC_W-1:0]          vecOut
);

  bankStrobe_t      strobe;
  logic [PTR_W-1:0] bankIdx;

  irq_bank_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .PTR_W    (PTR_W)
  ) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .excReq        (excReq),
    .excClass      (excClass_e'(excClass)),
    .bankEnable    (bankEnable),
    .overflowEnable(overflowEnable),
    .restoreReq    (restoreReq),
    .useBank       (useBank),
    .useStack      (useStack),
    .raiseOverflow (raiseOverflow),
    .underflowErr  (underflowErr),
    .restoreValid  (restoreValid),
    .bankPtr       (bankPtr),
    .strobe        (strobe),
    .bankIdx       (bankIdx)
  );

  irq_bank_store #(
    .NUM_BANKS(NUM_BANKS),
    .NUM_GPR  (NUM_GPR),
    .DATA_W   (DATA_W),
    .VEC_W    (VEC_W),
    .PTR_W    (PTR_W)
  ) store_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .bankIdx(bankIdx),
    .gprIn  (gprIn),
    .gbrIn  (gbrIn),
    .machIn (machIn),
    .maclIn (maclIn),
    .prIn   (prIn),
    .vecIn  (vecIn),
    .gprOut (gprOut),
    .gbrOut (gbrOut),
    .machOut(machOut),
    .maclOut(maclOut),
    .prOut  (prOut),
    .vecOut (vecOut)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(!rstN) |-> (bankPtr == '0 && !useBank && !useStack && !raiseOverflow)) else $error("reset"); // R1

endmodule

// File: tb/irq_bank_ctl_tb.sv
module irq_bank_ctl_tb_top;

  localparam int NB      = 15;
  localparam int NG      = 15;
  localparam int DW      = 32;
  localparam int VW      = 8;
  localparam int PW      = $clog2(NB + 1);
  localparam int NWORDS  = NG + 4;
  localparam int ENTRY_W = NWORDS * DW + VW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic excReq = 1'b0;
  logic [2:0] excClass = '0;
  logic bankEnable = 1'b0;
  logic overflowEnable = 1'b0;
  logic restoreReq = 1'b0;
  logic [ENTRY_W-1:0] drvEntry = '0;
  logic useBank, useStack, raiseOverflow, underflowErr, restoreValid;
  logic [PW-1:0] bankPtr;
  logic [NG*DW-1:0] gprOut;
  logic [DW-1:0] gbrOut, machOut, maclOut, prOut;
  logic [VW-1:0] vecOut;

  int vecCnt = 0;
  int errCnt = 0;
  bit done = 1'b0;

  logic [ENTRY_W-1:0] modelMem [NB];
  int modelPtr = 0;

  always #2.5 clk = ~clk;

  // Entry layout in the bench: {vec, pr, macl, mach, gbr, gpr}
  irq_bank_ctl dut_i (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excClass(excClass),
    .bankEnable(bankEnable), .overflowEnable(overflowEnable), .restoreReq(restoreReq),
    .gprIn (drvEntry[NG*DW-1:0]),
    .gbrIn (drvEntry[NG*DW +: DW]),
    .machIn(drvEntry[(NG+1)*DW +: DW]),
    .maclIn(drvEntry[(NG+2)*DW +: DW]),
    .prIn  (drvEntry[(NG+3)*DW +: DW]),
    .vecIn (drvEntry[NWORDS*DW +: VW]),
    .useBank(useBank), .useStack(useStack), .raiseOverflow(raiseOverflow),
    .underflowErr(underflowErr), .restoreValid(restoreValid), .bankPtr(bankPtr),
    .gprOut(gprOut), .gbrOut(gbrOut), .machOut(machOut), .maclOut(maclOut),
    .prOut(prOut), .vecOut(vecOut)
  );

  function automatic logic [ENTRY_W-1:0] randEntry();
    logic [ENTRY_W-1:0] e;
    for (int w = 0; w < NWORDS; w++) e[w*DW +: DW] = $urandom;
    e[NWORDS*DW +: VW] = VW'($urandom);
    return e;
  endfunction

  function automatic logic [ENTRY_W-1:0] outEntry();
    return {vecOut, prOut, maclOut, machOut, gbrOut, gprOut};
  endfunction

  task automatic check(input string req, input logic [ENTRY_W-1:0] act, input logic [ENTRY_W-1:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply one cycle of stimulus, predict, then check after the edge
  task automatic doOp(input bit req, input logic [2:0] cls, input bit ben, input bit ovf, input bit rst);
    logic [4:0] expFlags;
    logic [ENTRY_W-1:0] expData;
    string tag;
    bit elig;
    expFlags = '0;
    expData = '0;
    tag = "R2";
    drvEntry = randEntry();
    excReq = req; excClass = cls; bankEnable = ben; overflowEnable = ovf; restoreReq = rst;
    if (req) begin
      elig = (cls == 3'd0) && ben;
      if (!elig) begin
        expFlags[3] = 1'b1;
        tag = (cls != 3'd0) ? "R3" : "R4";
      end else if (modelPtr < NB) begin
        expFlags[4] = 1'b1;
        modelMem[modelPtr] = drvEntry;
        modelPtr++;
        tag = "R5";
      end else if (ovf) begin
        expFlags[2] = 1'b1;
        tag = "R7";
      end else begin
        expFlags[3] = 1'b1;
        tag = "R6";
      end
      if (rst) tag = {tag, "/R10"};
    end else if (rst) begin
      if (modelPtr == 0) begin
        expFlags[1] = 1'b1;
        tag = "R9";
      end else begin
        modelPtr--;
        expFlags[0] = 1'b1;
        expData = modelMem[modelPtr];
        tag = "R8";
      end
    end
    @(negedge clk);
    excReq = 1'b0; restoreReq = 1'b0;
    check({tag, " flags"}, ENTRY_W'({useBank, useStack, raiseOverflow, underflowErr, restoreValid}),
          ENTRY_W'(expFlags));
    check({tag, " bankPtr"}, ENTRY_W'(bankPtr), ENTRY_W'(modelPtr));
    if (expFlags[0]) check({tag, " restored context"}, outEntry(), expData);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7203));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1 reset flags", ENTRY_W'({useBank, useStack, raiseOverflow, underflowErr, restoreValid}), '0);
    check("R1 reset bankPtr", ENTRY_W'(bankPtr), '0);
    doOp(0, 0, 1, 0, 0);              // idle, R2
    doOp(0, 0, 1, 0, 1);              // R9 underflow at 0
    for (int c = 1; c < 8; c++) doOp(1, 3'(c), 1, 0, 0); // R3
    doOp(1, 0, 0, 0, 0);              // R4
    doOp(1, 0, 1, 0, 0);              // R5
    doOp(1, 0, 1, 0, 1);              // R10
    doOp(0, 0, 1, 0, 1);              // R8
    doOp(0, 0, 1, 0, 1);              // R8
    doOp(0, 0, 1, 0, 1);              // R9
    for (int i = 0; i < NB; i++) doOp(1, 0, 1, 0, 0); // fill, R5
    doOp(1, 0, 1, 0, 0);              // R6 full fallback
    doOp(1, 0, 1, 1, 0);              // R7 overflow
    doOp(1, 0, 1, 1, 1);              // R7 + R10
    for (int i = 0; i < NB + 1; i++) doOp(0, 0, 1, 0, 1); // R8 LIFO then R9
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 45)
        doOp(1, ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'd0,
             $urandom_range(0, 7) != 0, 1'($urandom), 1'($urandom_range(0, 9) == 0));
      else if (r < 85)
        doOp(0, 0, 1, 0, 1);
      else
        doOp(0, 0, 1, 0, 0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule